// File: doc/BRIEF.md
# Programmable Handshake Delay Timer

This block times the output handshake of one parallel port group. When the port signals that its data is valid, the block waits a programmed delay and then drives the control strobe true. It holds the strobe until the peripheral acknowledges. It then drops the strobe, pulses a completion flag for one cycle and returns to idle.

The delay is a 4-bit factor multiplied by a decade time unit of 1 µs, 10 µs, 100 µs or 1 ms. The unit comes from a divider chain that starts at a parameterized number of clock cycles per microsecond. Two byte-wide registers can be written and read back:
- a delay register holding the factor and the range code;
- a control register holding the handshake type and an enable-inhibit bit.

With inhibit enabled, a BUSY level on the peripheral status input freezes the delay count, and the count resumes when status returns to READY. Handshake types that mean "no handshake" complete a transfer at once without touching the strobe.

Top module: `hsk_delay_timer`

## Requirements
- R1: After reset, `ctl` and `done` are 0 and both registers read back 0x00.
- R2: A write with `wr_sel`=0 stores `wr_data` in the delay register, and it reads back unchanged with `rd_sel`=0. The factor is in bits 7:4. The range code is in bits 1:0: 00 gives 1 ms, 01 gives 100 µs, 10 gives 10 µs and 11 gives 1 µs.
- R3: A delay-register write is accepted only when `grp_sel` equals parameter `GROUP_ID`. With any other `grp_sel` value, the write leaves the delay register unchanged.
- R4: A write with `wr_sel`=1 stores `wr_data` in the control register, and it reads back unchanged with `rd_sel`=1. The handshake type is in bits 7:5 and enable-inhibit is in bit 4.
- R5: When `data_valid` is sampled in idle with a nonzero factor F, `ctl` rises exactly F×U clock edges after the sampling edge. U is CLK_PER_US times 1000, 100, 10 or 1, chosen by the range code.
- R6: With factor 0 and no inhibit, `ctl` is 1 right after the edge that samples `data_valid`.
- R7: Handshake types 000, 110 and 111 mean no handshake. For these types, `done` is 1 for the one cycle after the edge that samples `data_valid`, and `ctl` stays 0.
- R8: With enable-inhibit set, each delay-phase edge that sees `busy`=1 is added to the delay, and the count resumes where it stopped. With enable-inhibit clear, `busy` has no effect.
- R9: `ctl` stays 1 until an edge samples `ack`=1. That edge clears `ctl` and raises `done` for one cycle, and the block then accepts a new transfer.
- R10: The factor and range are captured when the transfer starts. Register writes during the delay do not change that transfer's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 delay, 1 control |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 delay, 1 control |
| rd_data | output | 8 | Read data (combinational) |
| grp_sel | input | GRP_W | Port group chosen by the card control |
| data_valid | input | 1 | Port data has become valid |
| busy | input | 1 | Peripheral status, 1 = BUSY |
| ack | input | 1 | Peripheral acknowledge |
| ctl | output | 1 | Control strobe |
| done | output | 1 | One-cycle transfer completion |

## Verification
The assertions assume that `ack` is raised only while the strobe is high and that `data_valid` arrives only in idle. The bench keeps to this by pulsing `data_valid` for a single cycle and asserting `ack` only after it has seen `ctl` high. Register writes and changes to `busy` are made half a cycle away from the active edge, so each edge sees exactly one defined value. The bench shrinks CLK_PER_US to 2 so that the millisecond range fits in a short run, while every decade stage is still exercised.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
   localparam int NUM_DECADES = 4;
   localparam int HT_W        = 3;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WAIT   = 2'd1,
      ST_STROBE = 2'd2
   } xfer_st_t;

   // Codes 0, 6 and 7 perform no handshake.
   function automatic logic hs_passive(input logic [HT_W-1:0] t);
      return (t == 3'd0) || (t > 3'd5);
   endfunction
endpackage

// File: rtl/hsk_delay_regs.sv
module hsk_delay_regs #(
   parameter int GRP_W    = 2,
   parameter int GROUP_ID = 0,
   parameter int FACT_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [7:0]       wr_data,
   input  logic             rd_sel,
   input  logic [GRP_W-1:0] grp_sel,
   output logic [7:0]       rd_data,
   output logic [FACT_W-1:0] factor,
   output logic [1:0]       range_code,
   output logic [2:0]       hs_type,
   output logic             inh_en
);
   localparam logic [GRP_W-1:0] MY_GRP = GRP_W'(GROUP_ID);

   logic [7:0] dly_q, cfg_q;
   logic       grp_hit;

   initial begin
      if (FACT_W != 4) $error("FACT_W must be 4 to fit delay bits 7:4");
      if (GROUP_ID < 0 || GROUP_ID >= (1 << GRP_W)) $error("GROUP_ID out of range");
   end

   assign grp_hit = (grp_sel == MY_GRP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_q <= '0;
         cfg_q <= '0;
      end else if (wr_en) begin
         if (wr_sel)       cfg_q <= wr_data;
         else if (grp_hit) dly_q <= wr_data;
      end
   end

   assign rd_data    = rd_sel ? cfg_q : dly_q;
   assign factor     = dly_q[7:4];
   assign range_code = dly_q[1:0];
   assign hs_type    = cfg_q[7:5];
   assign inh_en     = cfg_q[4];

   p_foreign_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && !grp_hit) |=> $stable(dly_q));
   p_cfg_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> (cfg_q == $past(wr_data)));
endmodule

// File: rtl/hsk_decade_chain.sv
module hsk_decade_chain #(
   parameter int CLK_PER_US = 125
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic [1:0] range_code,
   output logic       sel_tick
);
   import hsk_pkg::*;
   localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

   logic [NUM_DECADES-1:0] tk;

   initial begin
      if (CLK_PER_US < 1) $error("CLK_PER_US must be at least 1");
   end

   generate
      if (CLK_PER_US == 1) begin : g_pre_bypass
         assign tk[0] = en;
      end else begin : g_pre_div
         logic [PW-1:0] pc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  pc <= '0;
            else if (clr) pc <= '0;
            else if (en) pc <= (pc == PW'(CLK_PER_US-1)) ? '0 : pc + 1'b1;
         end
         assign tk[0] = en && (pc == PW'(CLK_PER_US-1));
      end

      for (genvar i = 1; i < NUM_DECADES; i++) begin : g_dec
         logic [3:0] dc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      dc <= '0;
            else if (clr)    dc <= '0;
            else if (tk[i-1]) dc <= (dc == 4'd9) ? 4'd0 : dc + 4'd1;
         end
         assign tk[i] = tk[i-1] && (dc == 4'd9);
      end
   endgenerate

   // Range 00 picks the slowest tick (1 ms), 11 the fastest (1 us).
   assign sel_tick = tk[~range_code];

   p_tick_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sel_tick |-> en);
endmodule

// File: rtl/hsk_xfer_fsm.sv
module hsk_xfer_fsm #(
   parameter int FACT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_valid,
   input  logic              busy,
   input  logic              ack,
   input  logic              inh_en,
   input  logic [2:0]        hs_type,
   input  logic [FACT_W-1:0] factor,
   input  logic [1:0]        range_code,
   input  logic              sel_tick,
   output logic              presc_clr,
   output logic              presc_en,
   output logic [1:0]        rng_q,
   output logic              ctl,
   output logic              done
);
   import hsk_pkg::*;

   xfer_st_t          st;
   logic [FACT_W-1:0] cnt;
   logic              ctl_q, done_q, inh, passive;

   assign inh       = inh_en && busy;
   assign passive   = hs_passive(hs_type);
   assign presc_clr = (st == ST_IDLE);
   assign presc_en  = (st == ST_WAIT) && !inh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         rng_q  <= '0;
         ctl_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: if (data_valid) begin
               rng_q <= range_code;
               if (passive) done_q <= 1'b1;
               else if (factor == '0 && !inh) begin
                  st    <= ST_STROBE;
                  ctl_q <= 1'b1;
               end else begin
                  st  <= ST_WAIT;
                  cnt <= factor;
               end
            end
            ST_WAIT: if (!inh) begin
               if (cnt == '0 || (sel_tick && cnt == FACT_W'(1))) begin
                  st    <= ST_STROBE;
                  ctl_q <= 1'b1;
                  cnt   <= '0;
               end else if (sel_tick) cnt <= cnt - 1'b1;
            end
            ST_STROBE: if (ack) begin
               st     <= ST_IDLE;
               ctl_q  <= 1'b0;
               done_q <= 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign ctl  = ctl_q;
   assign done = done_q;

   p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && data_valid && passive) |=> (done && !ctl));
   p_zero_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && data_valid && !passive && factor == '0 && !inh) |=> ctl);
   p_inhibit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && inh) |=> (st == ST_WAIT && $stable(cnt)));
   p_strobe_until_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl && !ack) |=> ctl);
   p_release_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl) |-> done);
endmodule

// File: rtl/hsk_delay_timer.sv
module hsk_delay_timer #(
   parameter int CLK_PER_US = 125,
   parameter int GRP_W      = 2,
   parameter int GROUP_ID   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [7:0]       wr_data,
   input  logic             rd_sel,
   output logic [7:0]       rd_data,
   input  logic [GRP_W-1:0] grp_sel,
   input  logic             data_valid,
   input  logic             busy,
   input  logic             ack,
   output logic             ctl,
   output logic             done
);
   localparam int FACT_W = 4;

   logic [FACT_W-1:0] factor;
   logic [1:0]        range_code, rng_q;
   logic [2:0]        hs_type;
   logic              inh_en, sel_tick, presc_clr, presc_en;

   hsk_delay_regs #(.GRP_W(GRP_W), .GROUP_ID(GROUP_ID), .FACT_W(FACT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .grp_sel(grp_sel), .rd_data(rd_data), .factor(factor),
      .range_code(range_code), .hs_type(hs_type), .inh_en(inh_en));

   hsk_decade_chain #(.CLK_PER_US(CLK_PER_US)) u_chain (
      .clk(clk), .rst_n(rst_n), .clr(presc_clr), .en(presc_en),
      .range_code(rng_q), .sel_tick(sel_tick));

   hsk_xfer_fsm #(.FACT_W(FACT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .data_valid(data_valid), .busy(busy), .ack(ack),
      .inh_en(inh_en), .hs_type(hs_type), .factor(factor), .range_code(range_code),
      .sel_tick(sel_tick), .presc_clr(presc_clr), .presc_en(presc_en),
      .rng_q(rng_q), .ctl(ctl), .done(done));
endmodule

// File: tb/sim_hsk_delay_timer.sv
`timescale 1ns/1ps
module sim_hsk_delay_timer;
   localparam int CPU = 2;
   localparam int GID = 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [1:0] grp_sel = 2'(GID);
   logic data_valid = 1'b0, busy = 1'b0, ack = 1'b0;
   logic ctl, done;
   int total = 0, bad = 0;

   always #4 clk = ~clk;

   hsk_delay_timer #(.CLK_PER_US(CPU), .GRP_W(2), .GROUP_ID(GID)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .grp_sel(grp_sel), .data_valid(data_valid),
      .busy(busy), .ack(ack), .ctl(ctl), .done(done));

   // {factor, range code, expected edges until ctl}
   localparam int VEC [8][3] = '{
      '{3, 3, 3*CPU},       '{1, 2, 10*CPU},   '{5, 1, 500*CPU},  '{0, 0, 0},
      '{15, 3, 15*CPU},     '{2, 0, 2000*CPU}, '{15, 2, 150*CPU}, '{0, 3, 0}};

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input bit sel, input logic [7:0] d, input logic [1:0] g);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d; grp_sel = g;
      @(negedge clk);
      wr_en = 1'b0; grp_sel = 2'(GID);
   endtask

   task automatic rd(input bit sel, output logic [7:0] d);
      @(negedge clk);
      rd_sel = sel;
      #1 d = rd_data;
   endtask

   // Starts a transfer; returns edges after the sampling edge until ctl is high.
   // busy is 1 for counted edges n in [b_from, b_to); mid_wr rewrites delay at n==2.
   task automatic run(input int b_from, input int b_to, input bit mid_wr, output int n);
      @(negedge clk);
      data_valid = 1'b1;
      @(posedge clk);
      #1 data_valid = 1'b0;
      n = 0;
      while (!ctl && n < 60000) begin
         busy = (n >= b_from && n < b_to);
         if (mid_wr && n == 2) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h10; end
         else wr_en = 1'b0;
         @(posedge clk);
         #1 n++;
      end
      busy = 1'b0; wr_en = 1'b0;
   endtask

   task automatic release_ack();
      repeat (2) @(posedge clk);
      #1 chk(ctl && !done, "R9 ctl held without ack", {ctl, done}, 2);
      @(negedge clk) ack = 1'b1;
      @(posedge clk);
      #1 chk(!ctl && done, "R9 release on ack", {ctl, done}, 1);
      ack = 1'b0;
      @(posedge clk);
      #1 chk(!done, "R9 done single cycle", done, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      int n;
      repeat (3) @(posedge clk);
      #1 chk(!ctl && !done, "R1 reset outputs", {ctl, done}, 0);
      rd(1'b0, d); chk(d == 8'h00, "R1 delay reg reset", d, 0);
      rd(1'b1, d); chk(d == 8'h00, "R1 control reg reset", d, 0);
      @(negedge clk) rst_n = 1'b1;

      wr(1'b1, 8'hB5, 2'(GID)); rd(1'b1, d); chk(d == 8'hB5, "R4 control readback", d, 8'hB5);
      wr(1'b1, 8'h20, 2'(GID)); rd(1'b1, d); chk(d == 8'h20, "R4 leading-edge mode", d, 8'h20);
      wr(1'b0, 8'h53, 2'(GID)); rd(1'b0, d); chk(d == 8'h53, "R2 delay readback", d, 8'h53);
      wr(1'b0, 8'hAA, 2'd2);    rd(1'b0, d); chk(d == 8'h53, "R3 foreign group ignored", d, 8'h53);
      wr(1'b0, 8'hC6, 2'd0);    rd(1'b0, d); chk(d == 8'h53, "R3 group 0 ignored", d, 8'h53);

      foreach (VEC[i]) begin
         wr(1'b0, {VEC[i][0][3:0], 2'b00, VEC[i][1][1:0]}, 2'(GID));
         run(0, 0, 1'b0, n);
         chk(n == VEC[i][2], (VEC[i][0] == 0) ? "R6 zero factor" : "R5 delay length", n, VEC[i][2]);
         release_ack();
      end

      // R8: inhibit enabled, busy for 5 edges during delay of 4 us
      wr(1'b1, 8'h30, 2'(GID));
      wr(1'b0, 8'h43, 2'(GID));
      run(3, 8, 1'b0, n);
      chk(n == 4*CPU + 5, "R8 inhibit extends delay", n, 4*CPU + 5);
      release_ack();
      // R8: inhibit disabled, busy ignored
      wr(1'b1, 8'h20, 2'(GID));
      run(0, 100, 1'b0, n);
      chk(n == 4*CPU, "R8 busy ignored without enable", n, 4*CPU);
      release_ack();

      // R10: rewrite delay during the wait
      wr(1'b0, 8'hA3, 2'(GID));
      run(0, 0, 1'b1, n);
      chk(n == 10*CPU, "R10 captured at start", n, 10*CPU);
      release_ack();

      // R7: no-handshake codes
      foreach (VEC[i]) begin
         if (i < 3) begin
            logic [2:0] t;
            t = (i == 0) ? 3'd0 : ((i == 1) ? 3'd6 : 3'd7);
            wr(1'b1, {t, 5'b0}, 2'(GID));
            @(negedge clk) data_valid = 1'b1;
            @(posedge clk);
            #1 data_valid = 1'b0;
            chk(done && !ctl, "R7 immediate completion", {done, ctl}, 2);
            repeat (30) @(posedge clk);
            #1 chk(!ctl && !done, "R7 ctl never driven", {ctl, done}, 0);
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule